// File: doc/BRIEF.md
# Cascaded Bit-Serial Dual Arithmetic/Logic Unit

This block is a bit-serial execution datapath that performs two dependent register operations for one instruction. Two one-bit-wide arithmetic/logic units sit in series. The first unit combines the word held in a forwarding buffer with source operand 1. The second unit takes the first unit's serial result and combines it with source operand 2. The final word is stored in a destination buffer, which drives the result port. The same word is written back into the forwarding buffer, so the next instruction can chain on it.

Both source words are captured in parallel when a start strobe is accepted. They are then shifted out least-significant bit first, one bit per clock. The first unit works through its word in a first execute phase of W clocks. The second unit works through its word in a second execute phase of W clocks. While the first phase runs, a zero detector watches the bits of source operand 1. Its verdict is published when the second phase begins. A separate clear strobe resets the carry/borrow state of both units, the latched opcodes and the sequencer. A controller issues this strobe at the start of every instruction.

Top module: `casc_alu_top`

## Requirements
- R1: After reset, result_o is 0, done_o is 0, zero_o is 0 and the forwarding buffer holds 0.
- R2: Opcode 000 adds and opcode 001 subtracts, each modulo 2^W. Each unit has a carry/borrow flip-flop that feeds bit 0 of its operation.
- R3: Opcode 010 gives AND, opcode 011 gives OR and opcode 100 gives XOR of the unit's two operands. These opcodes leave the carry/borrow flip-flop unchanged.
- R4: Opcode 101 passes operand A. Opcode 110 passes operand B. The reserved opcode 111 behaves as pass A.
- R5: The result equals (F op_a src1) op_b src2. F is the forwarding buffer contents when start is accepted. Operand A of the first unit is F, and operand A of the second unit is the first unit's result.
- R6: The forwarding buffer takes the final result in the same cycle as the destination buffer. It changes at no other time.
- R7: done_o is high for exactly one cycle, after the 2*W-th rising edge that follows the edge accepting start_i. result_o holds the new word from that cycle on.
- R8: zero_o becomes 1 if src1 was all zeros and 0 otherwise. It updates on the W-th edge after start acceptance and holds its value until the next update.
- R9: A unit's carry/borrow value persists from one instruction to the next. Only clr_i or reset set it to 0.
- R10: A start_i pulse while an instruction is in progress is ignored. It changes neither the result, the done timing, nor the number of done pulses.
- R11: clr_i during an instruction aborts it. No done pulse follows, and result_o, the forwarding buffer and zero_o keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clears unit carries, latched opcodes and the sequencer |
| start_i | input | 1 | Captures operands and opcodes when the block is idle |
| op_a_i | input | 3 | Opcode of the first unit |
| op_b_i | input | 3 | Opcode of the second unit |
| src1_i | input | W | Source operand 1 |
| src2_i | input | W | Source operand 2 |
| result_o | output | W | Destination buffer contents |
| done_o | output | 1 | One-cycle pulse when a result is stored |
| zero_o | output | 1 | Source operand 1 was all zeros |

## Verification
The hardest states to reach from the ports are those that depend on history. One is a carry left behind by an earlier addition that never got cleared. Another is a forwarding buffer holding a value from a previous instruction. A third is an abort partway through the first phase. The bench drives these states with sequences of instructions: it overflows an addition and then omits the clear strobe, it loads the forwarding buffer with a pass-through instruction before chaining on it, and it pulses clear four cycles into an instruction. It also checks zero_o one cycle before and one cycle at its update edge, and it injects a second start strobe mid-instruction.

// File: rtl/casc_alu_pkg.sv
// Shared types for the cascaded serial ALU.
// Assumes 3-bit opcodes and a three-state sequencer.
package casc_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_XOR   = 3'b100,
        OP_PASSA = 3'b101,
        OP_PASSB = 3'b110,
        OP_RSVD  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_EX0  = 2'b01,
        PH_EX1  = 2'b10
    } phase_e;
endpackage

// File: rtl/casc_alu_unit.sv
// One-bit serial ALU slice with its carry/borrow flip-flop.
// Assumes operand bits arrive LSB first while en_i is high.
// clr_i has priority over en_i and zeroes the carry.
module casc_alu_unit
    import casc_alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr_i,
    input  logic    en_i,
    input  alu_op_e op_i,
    input  logic    a_i,
    input  logic    b_i,
    output logic    y_o
);
    logic carry_q;
    logic carry_d;

    // Bit result and next carry for the selected operation
    always_comb begin
        carry_d = carry_q;
        case (op_i)
            OP_ADD: begin
                y_o     = a_i ^ b_i ^ carry_q;
                carry_d = (a_i & b_i) | (carry_q & (a_i ^ b_i));
            end
            OP_SUB: begin
                y_o     = a_i ^ b_i ^ carry_q;
                carry_d = (~a_i & b_i) | (~(a_i ^ b_i) & carry_q);
            end
            OP_AND:   y_o = a_i & b_i;
            OP_OR:    y_o = a_i | b_i;
            OP_XOR:   y_o = a_i ^ b_i;
            OP_PASSB: y_o = b_i;
            default:  y_o = a_i;
        endcase
    end

    // Carry/borrow register, cleared by reset or the clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) carry_q <= 1'b0;
        else if (en_i)       carry_q <= carry_d;
    end

    a_r9_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (carry_q == 1'b0));

    a_r3_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !(op_i inside {OP_ADD, OP_SUB})) |=> $stable(carry_q));
endmodule

// File: rtl/casc_alu_seq.sv
// Sequencer for the two execute phases, W bit clocks each.
// Accepts start only when idle. clr_i aborts and returns to idle.
// done_o pulses for one cycle after the last bit of phase two.
module casc_alu_seq
    import casc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr_i,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   load_o,
    output logic   last_o,
    output logic   done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign phase_o = phase_q;
    assign last_o  = (cnt_q == CW'(W - 1));
    assign load_o  = start_i && !clr_i && (phase_q == PH_IDLE);

    // Phase and bit-counter progression
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (load_o) phase_q <= PH_EX0;
                end
                PH_EX0: begin
                    if (last_o) begin
                        phase_q <= PH_EX1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_EX1: begin
                    if (last_o) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        done_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_after_ex1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase_q) == PH_EX1));

    a_r11_clr_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !done_o);
endmodule

// File: rtl/casc_alu_top.sv
// Two serial ALUs in cascade. Unit A combines the forwarding buffer
// with src1, and unit B combines unit A's result with src2.
// Operands are captured on an accepted start and shifted LSB first.
// The final word goes to the destination and forwarding buffers.
// Assumes clr_i is pulsed before an instruction that needs zero carries.
module casc_alu_top
    import casc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         start_i,
    input  logic [2:0]   op_a_i,
    input  logic [2:0]   op_b_i,
    input  logic [W-1:0] src1_i,
    input  logic [W-1:0] src2_i,
    output logic [W-1:0] result_o,
    output logic         done_o,
    output logic         zero_o
);
    phase_e phase;
    logic   load, last;
    logic   en_a, en_b;
    logic   y_a, y_b;

    alu_op_e      opa_q, opb_q;
    logic [W-1:0] s1_sh, s2_sh, fa_sh, mid_sh, res_sh;
    logic [W-1:0] fb_q, dst_q;
    logic         zacc_q, zero_q;

    assign en_a     = (phase == PH_EX0);
    assign en_b     = (phase == PH_EX1);
    assign result_o = dst_q;
    assign zero_o   = zero_q;

    casc_alu_seq #(.W(W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .start_i (start_i),
        .phase_o (phase),
        .load_o  (load),
        .last_o  (last),
        .done_o  (done_o)
    );

    casc_alu_unit i_unit_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (en_a),
        .op_i  (opa_q),
        .a_i   (fa_sh[0]),
        .b_i   (s1_sh[0]),
        .y_o   (y_a)
    );

    casc_alu_unit i_unit_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .en_i  (en_b),
        .op_i  (opb_q),
        .a_i   (mid_sh[0]),
        .b_i   (s2_sh[0]),
        .y_o   (y_b)
    );

    // Opcode decoder state: latched on start, cleared by reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            opa_q <= OP_ADD;
            opb_q <= OP_ADD;
        end else if (load) begin
            opa_q <= alu_op_e'(op_a_i);
            opb_q <= alu_op_e'(op_b_i);
        end
    end

    // Operand and intermediate shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sh  <= '0;
            s2_sh  <= '0;
            fa_sh  <= '0;
            mid_sh <= '0;
            res_sh <= '0;
            zacc_q <= 1'b0;
        end else if (load) begin
            s1_sh  <= src1_i;
            s2_sh  <= src2_i;
            fa_sh  <= fb_q;
            zacc_q <= 1'b0;
        end else if (en_a && !clr_i) begin
            s1_sh  <= s1_sh >> 1;
            fa_sh  <= fa_sh >> 1;
            mid_sh <= {y_a, mid_sh[W-1:1]};
            zacc_q <= zacc_q | s1_sh[0];
        end else if (en_b && !clr_i) begin
            s2_sh  <= s2_sh >> 1;
            mid_sh <= mid_sh >> 1;
            res_sh <= {y_b, res_sh[W-1:1]};
        end
    end

    // Zero flag published at the end of phase one
    always_ff @(posedge clk) begin
        if (!rst_n)                         zero_q <= 1'b0;
        else if (en_a && last && !clr_i)    zero_q <= ~(zacc_q | s1_sh[0]);
    end

    // Destination and forwarding buffers loaded with the final word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            fb_q  <= '0;
        end else if (en_b && last && !clr_i) begin
            dst_q <= {y_b, res_sh[W-1:1]};
            fb_q  <= {y_b, res_sh[W-1:1]};
        end
    end

    a_r6_fb_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_q != $past(fb_q)) |-> done_o);

    a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r8_zero_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_q != $past(zero_q)) |-> en_b);
endmodule

// File: tb/test_casc_alu_top.sv
module test_casc_alu_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_i = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   op_a_i = '0;
    logic [2:0]   op_b_i = '0;
    logic [W-1:0] src1_i = '0;
    logic [W-1:0] src2_i = '0;
    logic [W-1:0] result_o;
    logic         done_o;
    logic         zero_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [W-1:0] fb_m = '0;
    logic         ca_m = 1'b0;
    logic         cb_m = 1'b0;
    logic         zero_m = 1'b0;

    always #10 clk = ~clk;

    casc_alu_top #(.W(W)) i_casc_alu_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .start_i  (start_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .src1_i   (src1_i),
        .src2_i   (src2_i),
        .result_o (result_o),
        .done_o   (done_o),
        .zero_o   (zero_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] alu_ref(input logic [2:0] op,
            input logic [W-1:0] a, input logic [W-1:0] b,
            input logic cin, output logic cout);
        logic [W:0] t;
        cout = cin;
        case (op)
            3'b000: begin t = {1'b0, a} + {1'b0, b} + W'(cin); cout = t[W]; return t[W-1:0]; end
            3'b001: begin t = {1'b0, a} - {1'b0, b} - W'(cin); cout = t[W]; return t[W-1:0]; end
            3'b010: return a & b;
            3'b011: return a | b;
            3'b100: return a ^ b;
            3'b110: return b;
            default: return a;
        endcase
    endfunction

    task automatic pulse_clr();
        @(negedge clk) clr_i = 1'b1;
        @(negedge clk) clr_i = 1'b0;
        ca_m = 1'b0;
        cb_m = 1'b0;
    endtask

    // One instruction; inject > 0 pulses an extra start at that cycle
    task automatic run(input logic [2:0] oa, input logic [2:0] ob,
                       input logic [W-1:0] s1, input logic [W-1:0] s2,
                       input bit do_clr, input int inject, input string req);
        logic [W-1:0] mid, res;
        logic         c_n;
        int           n;
        if (do_clr) pulse_clr();
        mid = alu_ref(oa, fb_m, s1, ca_m, c_n); ca_m = c_n;
        res = alu_ref(ob, mid, s2, cb_m, c_n);  cb_m = c_n;
        @(negedge clk);
        start_i = 1'b1; op_a_i = oa; op_b_i = ob; src1_i = s1; src2_i = s2;
        @(negedge clk);
        start_i = 1'b0; src1_i = ~s1; src2_i = ~s2; op_a_i = ~oa; op_b_i = ~ob;
        n = 0;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
            start_i = (inject > 0 && n == inject);
            if (n == 7) chk(zero_o == zero_m, "R8", "zero before update", zero_o, zero_m);
            if (n == 8) chk(zero_o == (s1 == '0), "R8", "zero at update", zero_o, (s1 == '0));
            if (n < 16) chk(!done_o, "R7", "early done", n, 16);
        end
        start_i = 1'b0;
        zero_m = (s1 == '0);
        chk(n == 16, "R7", "done cycle", n, 16);
        chk(result_o == res, req, "result", result_o, res);
        fb_m = res;
        @(negedge clk);
        chk(!done_o, "R7", "done width", done_o, 0);
        chk(result_o == res, "R7", "result held", result_o, res);
    endtask

    task automatic t_reset();
        chk(result_o == '0, "R1", "reset result", result_o, 0);
        chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
        chk(zero_o == 1'b0, "R1", "reset zero", zero_o, 0);
        run(3'b101, 3'b101, 8'h5A, 8'hC3, 1'b1, 0, "R1");
    endtask

    task automatic t_arith();
        run(3'b110, 3'b000, 8'h37, 8'h29, 1'b1, 0, "R2");
        run(3'b110, 3'b001, 8'h10, 8'h25, 1'b1, 0, "R2");
        run(3'b000, 3'b001, 8'h44, 8'h0F, 1'b1, 0, "R5");
    endtask

    task automatic t_logic();
        run(3'b010, 3'b011, 8'hF0, 8'h03, 1'b1, 0, "R3");
        run(3'b100, 3'b010, 8'hFF, 8'h3C, 1'b1, 0, "R3");
    endtask

    task automatic t_pass();
        run(3'b110, 3'b110, 8'h11, 8'hA7, 1'b1, 0, "R4");
        run(3'b111, 3'b101, 8'h22, 8'h99, 1'b1, 0, "R4");
        run(3'b101, 3'b111, 8'h00, 8'h66, 1'b1, 0, "R4");
    endtask

    task automatic t_forward();
        run(3'b110, 3'b101, 8'h81, 8'h00, 1'b1, 0, "R6");
        run(3'b101, 3'b000, 8'hEE, 8'h01, 1'b1, 0, "R6");
        run(3'b011, 3'b100, 8'h0C, 8'h55, 1'b1, 0, "R5");
    endtask

    task automatic t_zero();
        run(3'b110, 3'b101, 8'h00, 8'h12, 1'b1, 0, "R8");
        run(3'b110, 3'b101, 8'h80, 8'h12, 1'b1, 0, "R8");
        run(3'b110, 3'b101, 8'h00, 8'h34, 1'b1, 0, "R8");
    endtask

    task automatic t_carry();
        run(3'b110, 3'b000, 8'hFF, 8'h01, 1'b1, 0, "R9");
        run(3'b110, 3'b000, 8'h10, 8'h20, 1'b0, 0, "R9");
        run(3'b110, 3'b001, 8'h00, 8'h01, 1'b1, 0, "R9");
        run(3'b110, 3'b001, 8'h30, 8'h10, 1'b0, 0, "R9");
        run(3'b110, 3'b000, 8'h30, 8'h10, 1'b1, 0, "R9");
    endtask

    task automatic t_busy();
        run(3'b110, 3'b000, 8'h21, 8'h13, 1'b1, 5, "R10");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!done_o, "R10", "extra done", done_o, 0);
        end
        run(3'b110, 3'b011, 8'h40, 8'h04, 1'b1, 12, "R10");
    endtask

    task automatic t_abort();
        logic [W-1:0] keep;
        keep = result_o;
        pulse_clr();
        @(negedge clk);
        start_i = 1'b1; op_a_i = 3'b110; op_b_i = 3'b101; src1_i = 8'h00; src2_i = 8'h77;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clr();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!done_o, "R11", "done after abort", done_o, 0);
        end
        chk(result_o == keep, "R11", "result after abort", result_o, keep);
        chk(zero_o == zero_m, "R11", "zero after abort", zero_o, zero_m);
        run(3'b101, 3'b101, 8'h5C, 8'hC5, 1'b1, 0, "R11");
    endtask

    initial begin
        #(20 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_pass();
        t_forward();
        t_zero();
        t_carry();
        t_busy();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule